// File: doc/BRIEF.md
# Self-Synchronous 64b/66b Scrambler and Descrambler Pair

This block holds two independent streaming lanes for 64b/66b line coding. The transmit lane scrambles a parallel payload word. The receive lane descrambles a parallel word taken from the line. Both lanes use the generator x^58 + x^39 + 1. Each lane keeps a 58-bit shift state. A word of configurable width is taken in on any cycle with its valid strobe high. The result comes out registered on the next cycle with a matching valid strobe.

Within a word, bit 0 is the earliest bit in time. The transmit lane shifts its own scrambled bits into the state. The receive lane shifts the line bits it receives. The receive state therefore fills with the last 58 line bits, whatever it started from. No seed has to be exchanged: after 58 bits of a correct stream, the receive lane returns the original payload. Sync-header handling, block alignment and width conversion sit outside this block.

Top module: `sss_pair`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, each lane loads its seed parameter into its state (all ones by default), drives its valid output low and drives its data output to zero.
- R2: For a valid transmit word, output bit i (bit 0 first in time) equals input bit i XOR state bit 38 XOR state bit 57. Here the state is the one reached after bits 0..i-1, and after each bit that output bit is shifted into state bit 0.
- R3: Each lane's valid output equals its valid input of the previous cycle, and the data output carries the result for the word that was valid in that cycle.
- R4: On a cycle where a lane's valid input is low, that lane's state and data output do not change.
- R5: For a valid receive word, output bit i equals received bit i XOR state bit 38 XOR state bit 57, and the received bit (not the output bit) is shifted into state bit 0.
- R6: When the transmit output feeds the receive input, every receive output bit that has at least 58 line bits before it since the receive state was last seeded or desynchronised equals the original payload bit, whatever the two seeds are.
- R7: Valid activity on one lane leaves the state and output of the other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| scr_valid_i | input | 1 | Transmit word valid |
| scr_data_i | input | W | Transmit payload word, bit 0 first |
| scr_valid_o | output | 1 | Scrambled word valid |
| scr_data_o | output | W | Scrambled word |
| dsc_valid_i | input | 1 | Received word valid |
| dsc_data_i | input | W | Received line word, bit 0 first |
| dsc_valid_o | output | 1 | Descrambled word valid |
| dsc_data_o | output | W | Descrambled payload word |

## Verification
A wrong transmit state shows up in the very next valid scrambled word, because every output bit mixes in two state bits. The error then persists, since the transmit state feeds back on itself. A wrong receive state is only visible in the first 58 bits after it arises, because received bits flush the state. For this reason the bench compares every descrambled bit against a bit-serial model, and it does not rely on payload recovery alone. The payload-recovery check is kept for the later bits and for the tail of the first word.

// File: rtl/sss_pkg.sv
// Package: shared constants and types for the scrambler pair.
// Assumes the x^58 + x^39 + 1 generator with bit 0 of a word first in time.
package sss_pkg;
    localparam int STATE_W = 58;
    localparam int TAP_HI  = 57;
    localparam int TAP_LO  = 38;

    typedef logic [STATE_W-1:0] state_t;

    // Selects which bit is shifted into the state.
    typedef enum logic {
        FEED_SELF = 1'b0,   // own output bit (scrambler)
        FEED_RX   = 1'b1    // received bit (descrambler)
    } feed_e;
endpackage

// File: rtl/sss_unroll.sv
// Module: sss_unroll
// Purely combinational unrolling of W serial steps of the 58-bit
// self-synchronous recurrence. FEED picks the bit shifted back into the
// state. Assumes bit 0 of din is the earliest bit in time.
module sss_unroll
    import sss_pkg::*;
#(
    parameter int    W    = 64,
    parameter feed_e FEED = FEED_SELF
) (
    input  state_t         state_i,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   dout,
    output state_t         state_o
);
    logic [W:0][STATE_W-1:0] chain;

    assign chain[0] = state_i;

    // One stage per bit: XOR with the two taps, then shift one place.
    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        logic obit;
        assign obit     = din[gi] ^ chain[gi][TAP_LO] ^ chain[gi][TAP_HI];
        assign dout[gi] = obit;
        if (FEED == FEED_RX) begin : g_rx
            assign chain[gi+1] = {chain[gi][STATE_W-2:0], din[gi]};
        end else begin : g_self
            assign chain[gi+1] = {chain[gi][STATE_W-2:0], obit};
        end
    end

    assign state_o = chain[W];
endmodule

// File: rtl/sss_lane.sv
// Module: sss_lane
// One registered scrambling lane: it holds the state and applies the unrolled
// recurrence to each valid word. The result appears one cycle later. Assumes
// a synchronous active-low reset and that the state advances only on valid.
module sss_lane
    import sss_pkg::*;
#(
    parameter int     W    = 64,
    parameter feed_e  FEED = FEED_SELF,
    parameter state_t SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic         valid_o,
    output logic [W-1:0] data_o,
    output state_t       state_o
);
    state_t       state_q;
    state_t       state_nxt;
    logic [W-1:0] word_nxt;
    logic [W-1:0] data_q;
    logic         valid_q;

    sss_unroll #(.W(W), .FEED(FEED)) u_unroll (
        .state_i (state_q),
        .din     (data_i),
        .dout    (word_nxt),
        .state_o (state_nxt)
    );

    // Seed on reset; otherwise advance state and capture the word on valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_i;
            if (valid_i) begin
                state_q <= state_nxt;
                data_q  <= word_nxt;
            end
        end
    end

    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign state_o = state_q;
endmodule

// File: rtl/sss_pair.sv
// Module: sss_pair
// Top level: a transmit scrambler lane and an independent receive
// descrambler lane. Assumes the caller handles sync headers and alignment.
module sss_pair
    import sss_pkg::*;
#(
    parameter int     W        = 64,
    parameter state_t SCR_SEED = '1,
    parameter state_t DSC_SEED = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         scr_valid_i,
    input  logic [W-1:0] scr_data_i,
    output logic         scr_valid_o,
    output logic [W-1:0] scr_data_o,
    input  logic         dsc_valid_i,
    input  logic [W-1:0] dsc_data_i,
    output logic         dsc_valid_o,
    output logic [W-1:0] dsc_data_o
);
    state_t scr_state;
    state_t dsc_state;

    // Transmit lane: its own scrambled bits feed the state.
    sss_lane #(.W(W), .FEED(FEED_SELF), .SEED(SCR_SEED)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (scr_valid_i),
        .data_i  (scr_data_i),
        .valid_o (scr_valid_o),
        .data_o  (scr_data_o),
        .state_o (scr_state)
    );

    // Receive lane: the received line bits feed the state.
    sss_lane #(.W(W), .FEED(FEED_RX), .SEED(DSC_SEED)) u_dsc (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (dsc_valid_i),
        .data_i  (dsc_data_i),
        .valid_o (dsc_valid_o),
        .data_o  (dsc_data_o),
        .state_o (dsc_state)
    );
endmodule

// File: rtl/sss_pair_chk.sv
// Module: sss_pair_chk
// Assertion checker bound to sss_pair. It observes the ports and the two
// lane states.
module sss_pair_chk
    import sss_pkg::*;
#(
    parameter int     W        = 64,
    parameter state_t SCR_SEED = '1,
    parameter state_t DSC_SEED = '1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         scr_valid_i,
    input logic [W-1:0] scr_data_i,
    input logic         scr_valid_o,
    input logic [W-1:0] scr_data_o,
    input state_t       scr_state,
    input logic         dsc_valid_i,
    input logic [W-1:0] dsc_data_i,
    input logic         dsc_valid_o,
    input logic [W-1:0] dsc_data_o,
    input state_t       dsc_state
);
    logic rst_seen = 1'b0;

    // Check the seeded, idle state one edge after a reset edge (R1).
    always @(posedge clk) begin
        if (rst_seen) begin
            a_r1_reset_state: assert (scr_state == SCR_SEED && dsc_state == DSC_SEED
                                      && !scr_valid_o && !dsc_valid_o
                                      && scr_data_o == '0 && dsc_data_o == '0)
                else $error("R1 reset state wrong");
        end
        rst_seen <= !rst_n;
    end

    a_r2_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        scr_valid_i |=> scr_data_o[0] == ($past(scr_data_i[0]) ^ $past(scr_state[TAP_LO])
                                          ^ $past(scr_state[TAP_HI])));
    a_r2_self_feed: assert property (@(posedge clk) disable iff (!rst_n)
        scr_valid_i |=> scr_state[0] == scr_data_o[W-1]);

    a_r3_scr_valid_up: assert property (@(posedge clk) disable iff (!rst_n)
        scr_valid_i |=> scr_valid_o);
    a_r3_scr_valid_dn: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_valid_i |=> !scr_valid_o);
    a_r3_dsc_valid_up: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid_i |=> dsc_valid_o);
    a_r3_dsc_valid_dn: assert property (@(posedge clk) disable iff (!rst_n)
        !dsc_valid_i |=> !dsc_valid_o);

    a_r4_scr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_valid_i |=> $stable(scr_state) && $stable(scr_data_o));
    a_r4_dsc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dsc_valid_i |=> $stable(dsc_state) && $stable(dsc_data_o));

    a_r5_rx_feed: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid_i |=> dsc_state[0] == $past(dsc_data_i[W-1]));

    // With a word of at least 58 bits, the receive state is fully flushed (R6).
    if (W >= STATE_W) begin : g_lock
        state_t tail;
        always_comb begin
            for (int k = 0; k < STATE_W; k++) tail[k] = dsc_data_i[W-1-k];
        end
        a_r6_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
            dsc_valid_i |=> dsc_state == $past(tail));
    end
endmodule

bind sss_pair sss_pair_chk #(.W(W), .SCR_SEED(SCR_SEED), .DSC_SEED(DSC_SEED)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scr_valid_i (scr_valid_i),
    .scr_data_i  (scr_data_i),
    .scr_valid_o (scr_valid_o),
    .scr_data_o  (scr_data_o),
    .scr_state   (scr_state),
    .dsc_valid_i (dsc_valid_i),
    .dsc_data_i  (dsc_data_i),
    .dsc_valid_o (dsc_valid_o),
    .dsc_data_o  (dsc_data_o),
    .dsc_state   (dsc_state)
);

// File: tb/sss_pair_test.sv
`timescale 1ns / 1ps
module sss_pair_test;
    localparam int          W     = 64;
    localparam logic [57:0] SCR_S = '1;
    localparam logic [57:0] DSC_S = 58'h123456789abcdef;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scr_vin = 1'b0;
    logic [W-1:0] scr_din = '0;
    logic         scr_vout;
    logic [W-1:0] scr_dout;
    logic         dsc_vout;
    logic [W-1:0] dsc_dout;
    logic         man_v = 1'b0;
    logic [W-1:0] man_d = '0;
    logic         chain = 1'b1;
    logic         dsc_vin;
    logic [W-1:0] dsc_din;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [57:0]  m_scr = SCR_S;
    logic [57:0]  m_dsc = DSC_S;
    logic [W-1:0] q_scr[$];
    logic [W-1:0] q_dsc[$];
    logic [W-1:0] q_plain[$];
    int           q_mode[$];   // 0 none, 1 bits 58 and up, 2 whole word
    logic [W-1:0] prev_scr = '0;
    logic [W-1:0] prev_dsc = '0;

    always #2 clk = ~clk;

    assign dsc_vin = chain ? scr_vout : man_v;
    assign dsc_din = chain ? scr_dout : man_d;

    sss_pair #(.W(W), .SCR_SEED(SCR_S), .DSC_SEED(DSC_S)) uut (
        .clk(clk), .rst_n(rst_n),
        .scr_valid_i(scr_vin), .scr_data_i(scr_din),
        .scr_valid_o(scr_vout), .scr_data_o(scr_dout),
        .dsc_valid_i(dsc_vin), .dsc_data_i(dsc_din),
        .dsc_valid_o(dsc_vout), .dsc_data_o(dsc_dout)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial models written from R2 and R5.
    task automatic scr_model(input logic [W-1:0] d, output logic [W-1:0] s);
        for (int i = 0; i < W; i++) begin
            s[i]  = d[i] ^ m_scr[38] ^ m_scr[57];
            m_scr = {m_scr[56:0], s[i]};
        end
    endtask

    task automatic dsc_model(input logic [W-1:0] r, output logic [W-1:0] p);
        for (int i = 0; i < W; i++) begin
            p[i]  = r[i] ^ m_dsc[38] ^ m_dsc[57];
            m_dsc = {m_dsc[56:0], r[i]};
        end
    endtask

    // Driver: a transmit word; in chained mode the receive result is also queued.
    task automatic send(input logic [W-1:0] d, input int mode);
        logic [W-1:0] s, p;
        @(posedge clk); #1;
        scr_vin = 1'b1; scr_din = d; man_v = 1'b0;
        scr_model(d, s);
        q_scr.push_back(s);
        if (chain) begin
            dsc_model(s, p);
            q_dsc.push_back(p); q_plain.push_back(d); q_mode.push_back(mode);
        end
    endtask

    // Driver: a word straight into the receive lane (unchained mode).
    task automatic send_rx(input logic [W-1:0] r);
        logic [W-1:0] p;
        @(posedge clk); #1;
        scr_vin = 1'b0; man_v = 1'b1; man_d = r;
        dsc_model(r, p);
        q_dsc.push_back(p); q_plain.push_back(r); q_mode.push_back(0);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
            scr_vin = 1'b0; man_v = 1'b0;
        end
    endtask

    task automatic do_reset();
        idle(3);
        rst_n = 1'b0;
        m_scr = SCR_S; m_dsc = DSC_S;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scr_vout && !dsc_vout, "R1 valid low after reset", {63'd0, scr_vout | dsc_vout}, '0);
        check(scr_dout == '0, "R1 scrambler data zero after reset", scr_dout, '0);
        check(dsc_dout == '0, "R1 descrambler data zero after reset", dsc_dout, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard queues as the lanes produce results.
    always @(negedge clk) begin
        if (rst_n) begin
            if (scr_vout) begin
                if (q_scr.size() == 0) check(1'b0, "R3 unexpected scrambler valid", scr_dout, '0);
                else begin
                    logic [W-1:0] e;
                    e = q_scr.pop_front();
                    check(scr_dout == e, "R2 scrambled word", scr_dout, e);
                end
            end else begin
                check(scr_dout == prev_scr, "R4 scrambler output held", scr_dout, prev_scr);
            end
            if (dsc_vout) begin
                if (q_dsc.size() == 0) check(1'b0, "R3 unexpected descrambler valid", dsc_dout, '0);
                else begin
                    logic [W-1:0] e, pl;
                    int md;
                    e = q_dsc.pop_front(); pl = q_plain.pop_front(); md = q_mode.pop_front();
                    check(dsc_dout == e, chain ? "R5 descrambled word" : "R7 direct receive word",
                          dsc_dout, e);
                    if (md == 2)
                        check(dsc_dout == pl, "R6 payload recovered", dsc_dout, pl);
                    else if (md == 1)
                        check((dsc_dout >> 58) == (pl >> 58), "R6 tail of first word recovered",
                              dsc_dout >> 58, pl >> 58);
                end
            end else begin
                check(dsc_dout == prev_dsc, "R4 or R7 descrambler output held", dsc_dout, prev_dsc);
            end
        end
        prev_scr <= scr_dout;
        prev_dsc <= dsc_dout;
    end

    initial begin
        #400000;
        check(1'b0, "watchdog expired", '0, '1);
        finish_run();
    end

    initial begin
        do_reset();
        // Chained run, seeds differ: first word only partly recovered.
        send('0, 1);
        send('1, 2);
        send(64'h0000_0000_0000_0001, 2);
        send(64'h8000_0000_0000_0000, 2);
        send(64'haaaa_aaaa_aaaa_aaaa, 2);
        for (int i = 0; i < 40; i++) send({$urandom, $urandom}, 2);
        // Gapped traffic.
        for (int i = 0; i < 20; i++) begin
            send({$urandom, $urandom}, 2);
            idle(1 + (i % 3));
        end
        idle(3);
        // Unchained: transmit alone, receive lane must hold (R7).
        chain = 1'b0;
        for (int i = 0; i < 5; i++) send({$urandom, $urandom}, 0);
        idle(3);
        check(q_scr.size() == 0, "R7 transmit drained while receive idle", '0, '0);
        for (int i = 0; i < 5; i++) send_rx({$urandom, $urandom});
        idle(3);
        // Re-chain: receive state is stale, relocks within one word (R6).
        chain = 1'b1;
        send(64'h0123_4567_89ab_cdef, 1);
        for (int i = 0; i < 10; i++) send({$urandom, $urandom}, 2);
        // Mid-stream reset back to the seeds (R1).
        do_reset();
        send(64'hdead_beef_0bad_f00d, 1);
        for (int i = 0; i < 10; i++) send({$urandom, $urandom}, 2);
        idle(4);
        check(q_scr.size() == 0 && q_dsc.size() == 0, "R3 every word produced once",
              W'(q_scr.size() + q_dsc.size()), '0);
        finish_run();
    end
endmodule